// File: doc/BRIEF.md
# Buffered Input Capture Timer

This block holds a free-running 16-bit up-counter and four capture channels, A to D. A qualifying edge on a channel's pin latches the current count into that channel's capture register and sets that channel's status flag. The counter advances on one of four count sources: the system clock divided by 2, 8 or 32, or the rising edge of an external clock pin. When it wraps from its all-ones value to zero, it sets an overflow flag.

Channels C and D can each be turned into a second stage behind channel A or channel B. In that pairing, every capture on the primary channel first moves the primary's old value into the secondary register. The primary then takes the new count. The secondary pin stops causing captures, and the secondary channel's edge-select bit decides which edge on the primary pin counts.

Software reaches the block through a small register port with a combinational read. It can set the control bits, read and preset the counter, read the capture registers, and clear flags by writing zeros.

Top module: `icap_timer`

## Requirements
- R1: The counter adds one on each enabled count tick and wraps from 0xFFFF to 0x0000. Without a tick it holds its value.
- R2: A wrap of the counter sets overflow flag bit 4 of the status register.
- R3: Control bits [1:0] select the count source: 0 gives system clock / 2, 1 gives / 8, 2 gives / 32, and 3 gives one count per synchronized rising edge of `ext_clk_pin`.
- R4: Each pin passes through a two-flop synchronizer. An edge-select bit of 0 captures on a falling edge and 1 on a rising edge. Control bits 7, 6, 5 and 4 are the selects for A, B, C and D. A pulse on a pin gives exactly one capture of the counter value.
- R5: With control bit 3 set (A/C pairing), a capture on pin A copies the old A register into C and loads the count into A in the same clock cycle.
- R6: With control bit 3 set, pin C has no effect: register C changes only through A captures, and flag C stays clear.
- R7: With control bit 3 set, the edge on pin A is chosen by the C edge-select bit (bit 5), and the A edge-select bit is ignored.
- R8: Control bit 2 pairs B with D in the same way as R5 to R7, with D's edge-select bit 4 choosing B's edge.
- R9: Status bits 0 to 3 are the capture flags of A to D. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A capture in the same cycle as a clearing write leaves the flag set.
- R10: Register map: 0 is control (8 bits), 1 is status, 2 is the counter, and 3 to 6 are captures A to D (read-only). All registers reset to zero.
- R11: A write to the counter register loads it and takes priority over a count tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 4 | Capture pins; bit 0 is A, bit 3 is D |
| ext_clk_pin | input | 1 | External count clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |

## Verification
Two pairs of events can land in the same clock cycle. A capture can set a flag while a status write clears it. A counter preset can meet a prescaler tick. For the first pair, the bench counts the two synchronizer stages so that its status write of zeros reaches the same edge as the capture, and it expects the flag to read as set. For the second pair, it presets the counter on two back-to-back cycles while the divide-by-2 source runs, so one of the writes must meet a tick, and it expects each read-back to equal the written value exactly.

// File: rtl/icap_pkg.sv
package icap_pkg;

   typedef enum logic [1:0] {
      CS_DIV_LO  = 2'd0,
      CS_DIV_MID = 2'd1,
      CS_DIV_HI  = 2'd2,
      CS_EXT     = 2'd3
   } icap_cs_e;

   typedef struct packed {
      logic     edge_a;
      logic     edge_b;
      logic     edge_c;
      logic     edge_d;
      logic     pair_ac;
      logic     pair_bd;
      icap_cs_e cs;
   } icap_ctrl_t;

   localparam int unsigned ADDR_W     = 3;
   localparam int unsigned N_CH       = 4;
   localparam int unsigned N_FLAGS    = N_CH + 1;
   localparam int unsigned OVF_BIT    = N_CH;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
   localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CAP0   = 3'd3;

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;

   // R4: a single edge yields a single-cycle pulse
   p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   p_single_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/icap_prescale.sv
module icap_prescale #(
   parameter int unsigned L2_LO  = 1,
   parameter int unsigned L2_MID = 3,
   parameter int unsigned L2_HI  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       ext_rise,
   output logic       tick
);
   if (!(L2_LO >= 1 && L2_LO < L2_MID && L2_MID < L2_HI)) begin : g_bad_div
      $error("icap_prescale: divider exponents must be ascending and non-zero");
   end

   localparam int unsigned PS_W = L2_HI;
   localparam logic [PS_W-1:0] M_LO  = PS_W'((1 << L2_LO) - 1);
   localparam logic [PS_W-1:0] M_MID = PS_W'((1 << L2_MID) - 1);
   localparam logic [PS_W-1:0] M_HI  = PS_W'((1 << L2_HI) - 1);

   logic [PS_W-1:0] pre_q;
   logic [2:0]      div_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign div_tick[0] = (pre_q & M_LO)  == M_LO;
   assign div_tick[1] = (pre_q & M_MID) == M_MID;
   assign div_tick[2] = (pre_q & M_HI)  == M_HI;

   always_comb begin
      unique case (sel)
         2'd0:    tick = div_tick[0];
         2'd1:    tick = div_tick[1];
         2'd2:    tick = div_tick[2];
         default: tick = ext_rise;
      endcase
   end

   // R3: slower internal ticks always coincide with faster ones
   p_nest_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick[2] |-> div_tick[1]);
   p_nest_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick[1] |-> div_tick[0]);
   p_lo_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick[0] |=> !div_tick[0]);
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   assign wrap = tick & ~load & (&cnt_q);

   p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> cnt_q == W'($past(cnt_q) + 1'b1));
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/icap_timer.sv
module icap_timer
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned L2_LO       = 1,
   parameter int unsigned L2_MID      = 3,
   parameter int unsigned L2_HI       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   cap_pin,
   input  logic              ext_clk_pin,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata
);
   if (CNT_W < N_FLAGS || CNT_W < $bits(icap_ctrl_t)) begin : g_bad_width
      $error("icap_timer: CNT_W too narrow for control and status");
   end

   localparam int unsigned N_PAIR = N_CH / 2;

   icap_ctrl_t        ctl_q;
   logic [N_CH-1:0]   rise, fall, hit;
   logic [N_CH-1:0]   edge_sel;
   logic [N_PAIR-1:0] paired;
   logic [CNT_W-1:0]  cap_q [N_CH];
   logic [N_FLAGS-1:0] flag_q;
   logic [CNT_W-1:0]  cnt;
   logic              wrap, ext_rise, ext_fall_unused, tick;
   logic              wr_ctrl, wr_stat, wr_cnt;

   assign wr_ctrl = reg_we && reg_addr == A_CTRL;
   assign wr_stat = reg_we && reg_addr == A_STATUS;
   assign wr_cnt  = reg_we && reg_addr == A_COUNT;

   assign edge_sel = {ctl_q.edge_d, ctl_q.edge_c, ctl_q.edge_b, ctl_q.edge_a};
   assign paired   = {ctl_q.pair_bd, ctl_q.pair_ac};

   always_ff @(posedge clk) begin
      if (!rst_n)       ctl_q <= '0;
      else if (wr_ctrl) ctl_q <= icap_ctrl_t'(reg_wdata[$bits(icap_ctrl_t)-1:0]);
   end

   // Pin synchronizers and edge detectors
   for (genvar i = 0; i < N_CH; i++) begin : g_pin
      icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(cap_pin[i]),
         .rise(rise[i]), .fall(fall[i]));
   end

   icap_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin),
      .rise(ext_rise), .fall(ext_fall_unused));

   icap_prescale #(.L2_LO(L2_LO), .L2_MID(L2_MID), .L2_HI(L2_HI)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(ctl_q.cs), .ext_rise(ext_rise), .tick(tick));

   icap_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_cnt),
      .load_val(reg_wdata), .cnt(cnt), .wrap(wrap));

   // Capture channels, organised as primary/secondary pairs
   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      localparam int unsigned PR = p;
      localparam int unsigned SE = p + N_PAIR;
      logic pr_edge;

      assign pr_edge = paired[p] ? edge_sel[SE] : edge_sel[PR];
      assign hit[PR] = pr_edge ? rise[PR] : fall[PR];
      assign hit[SE] = ~paired[p] & (edge_sel[SE] ? rise[SE] : fall[SE]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_q[PR] <= '0;
            cap_q[SE] <= '0;
         end else begin
            if (hit[PR]) cap_q[PR] <= cnt;
            if (paired[p] && hit[PR]) cap_q[SE] <= cap_q[PR];
            else if (hit[SE])         cap_q[SE] <= cnt;
         end
      end

      // R5 / R8: secondary takes the primary's old value
      p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (paired[p] && hit[PR]) |=> cap_q[SE] == $past(cap_q[PR]));
      // R6 / R8: secondary holds while paired and primary idle
      p_sec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (paired[p] && !hit[PR]) |=> $stable(cap_q[SE]));
      // R7 / R8: paired primary edge follows the secondary select
      p_pr_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (paired[p] && (edge_sel[SE] ? rise[PR] : fall[PR])) |=> cap_q[PR] == $past(cnt));
   end

   // Status flags: capture/overflow set has priority over a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else begin
         for (int i = 0; i < N_FLAGS; i++) begin
            if (wr_stat && !reg_wdata[i]) flag_q[i] <= 1'b0;
         end
         for (int i = 0; i < N_CH; i++) begin
            if (hit[i]) flag_q[i] <= 1'b1;
         end
         if (wrap) flag_q[OVF_BIT] <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL:   reg_rdata[$bits(icap_ctrl_t)-1:0] = ctl_q;
         A_STATUS: reg_rdata[N_FLAGS-1:0] = flag_q;
         A_COUNT:  reg_rdata = cnt;
         3'd3:     reg_rdata = cap_q[0];
         3'd4:     reg_rdata = cap_q[1];
         3'd5:     reg_rdata = cap_q[2];
         3'd6:     reg_rdata = cap_q[3];
         default:  reg_rdata = '0;
      endcase
   end

   p_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q[OVF_BIT]);
   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((flag_q & N_FLAGS'($past(hit))) == N_FLAGS'($past(hit))));
   p_ro_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr >= A_CAP0 && hit == '0) |=> $stable(cap_q[0]));
endmodule

// File: tb/icap_timer_tb.sv
module icap_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cap_pin = '0;
   logic        ext_clk_pin = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   icap_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .ext_clk_pin(ext_clk_pin),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata));

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [15:0] cnt;
      logic [3:0]  pins;
      logic [2:0]  addr;
      logic [15:0] expv;
      logic [4:0]  flg;
      logic [7:0]  req;
   } vec_t;

   // Captures with the counter frozen (external source, pin idle)
   localparam vec_t VEC [8] = '{
      '{8'h03, 16'h1234, 4'b0001, 3'd3, 16'h1234, 5'h01, 8'd4},  // R4 A falling
      '{8'h83, 16'h2222, 4'b0010, 3'd4, 16'h2222, 5'h02, 8'd4},  // R4 B
      '{8'h03, 16'h3333, 4'b0100, 3'd5, 16'h3333, 5'h04, 8'd4},  // R4 C
      '{8'h03, 16'h4444, 4'b1000, 3'd6, 16'h4444, 5'h08, 8'd4},  // R4 D
      '{8'h0B, 16'h5555, 4'b0001, 3'd5, 16'h1234, 5'h01, 8'd5},  // R5 A->C shift
      '{8'h0B, 16'h6666, 4'b0100, 3'd5, 16'h1234, 5'h00, 8'd6},  // R6 pin C ignored
      '{8'h07, 16'h7777, 4'b0010, 3'd6, 16'h2222, 5'h02, 8'd8},  // R8 B->D shift
      '{8'h0F, 16'h8888, 4'b0011, 3'd3, 16'h8888, 5'h03, 8'd8}   // R8 both pairs
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] expv);
      n_run++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, expv);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [15:0] v, c0, c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset values
      rd(3'd0, v); check("R10 ctrl reset", v, 16'h0000);
      rd(3'd1, v); check("R10 status reset", v, 16'h0000);
      rd(3'd3, v); check("R10 capA reset", v, 16'h0000);

      // Table walk: R4 R5 R6 R8 R9
      for (int i = 0; i < 8; i++) begin
         wr(3'd0, {8'h00, VEC[i].ctrl});
         wr(3'd2, VEC[i].cnt);
         wr(3'd1, 16'h0000);
         cap_pin = VEC[i].pins;
         settle(4);
         cap_pin = '0;
         settle(5);
         rd(VEC[i].addr, v);
         check($sformatf("R%0d vector %0d register", VEC[i].req, i), v, VEC[i].expv);
         rd(3'd1, v);
         check($sformatf("R%0d vector %0d flags (R9)", VEC[i].req, i), v, {11'd0, VEC[i].flg});
      end

      // R7: paired A uses C's select (rising), A's own select ignored
      wr(3'd0, 16'h002B);
      wr(3'd2, 16'h0100);
      cap_pin[0] = 1'b1; settle(5);
      rd(3'd3, v); check("R7 rising captures", v, 16'h0100);
      wr(3'd2, 16'h0200);
      cap_pin[0] = 1'b0; settle(5);
      rd(3'd3, v); check("R7 falling ignored", v, 16'h0100);
      rd(3'd5, v); check("R5 C holds old A", v, 16'h8888);
      wr(3'd0, 16'h008B);
      wr(3'd2, 16'h0300);
      cap_pin[0] = 1'b1; settle(5);
      rd(3'd3, v); check("R7 A select ignored", v, 16'h0100);
      wr(3'd2, 16'h0400);
      cap_pin[0] = 1'b0; settle(5);
      rd(3'd3, v); check("R7 falling via C select", v, 16'h0400);

      // R3: internal dividers, 64 system cycles each
      for (int s = 0; s < 3; s++) begin
         wr(3'd0, 16'(s));
         rd(3'd2, c0);
         settle(64);
         rd(3'd2, c1);
         check($sformatf("R3 divider sel %0d", s), c1 - c0, 16'(64 >> (2 * s + 1)));
      end

      // R3 / R1: external clock rising edges
      wr(3'd0, 16'h0003);
      rd(3'd2, c0);
      for (int k = 0; k < 5; k++) begin
         ext_clk_pin = 1'b1; settle(3);
         ext_clk_pin = 1'b0; settle(3);
      end
      settle(4);
      rd(3'd2, c1);
      check("R3 external edges", c1 - c0, 16'd5);

      // R11: preset on consecutive cycles while /2 runs
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h4000);
      rd(3'd2, v); check("R11 preset 1", v, 16'h4000);
      wr(3'd2, 16'h5000);
      rd(3'd2, v); check("R11 preset 2", v, 16'h5000);

      // R1 / R2: wrap and overflow
      wr(3'd1, 16'h0000);
      wr(3'd2, 16'hFFFE);
      settle(8);
      rd(3'd1, v); check("R2 overflow flag", v & 16'h0010, 16'h0010);
      rd(3'd2, v); check("R1 wrapped low", {15'd0, v < 16'h0010}, 16'h0001);

      // R9: write-1 keeps, write-0 clears
      wr(3'd0, 16'h0083);
      wr(3'd1, 16'h0000);
      cap_pin[0] = 1'b1; settle(5); cap_pin[0] = 1'b0; settle(3);
      wr(3'd1, 16'hFFFF);
      rd(3'd1, v); check("R9 write one keeps", v, 16'h0001);
      wr(3'd1, 16'hFFFE);
      rd(3'd1, v); check("R9 write zero clears", v, 16'h0000);

      // R9: capture and clearing write on the same edge
      cap_pin[0] = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      wr(3'd1, 16'h0000);
      rd(3'd1, v); check("R9 set beats clear", v, 16'h0001);
      cap_pin[0] = 1'b0; settle(4);

      summary();
   end
endmodule